// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block lets an SMBus target with an open-drain alert output take part in the host's alert query. The host issues a START followed by the reserved alert-response read address. An alerting target acknowledges that byte and then returns its own address byte. When several targets are alerting, the wired-AND bus settles which one gets through. The target whose byte appears intact on the line has been served, and it releases its alert output.

The block watches the synchronized SDA and SCL lines of its host interface. It drives only an SDA pull-down enable, and it computes the level of the EVENT pin from the polarity bit. It answers only while the device is in interrupt mode with an active-low EVENT, the response is enabled, and an alert is pending. The returned byte has a fixed upper nibble of `0011`, then the three strap pins, and ends with a bit that is always 0. Ordinary register reads and writes are handled elsewhere.

Top module: `ara_responder`

## Requirements
- R1: After reset `sda_pull` is 0 and, with an alert pending, EVENT is at its active level.
- R2: EVENT's active level equals `evt_pol` (0 means active-low) and its inactive level is the inverse. EVENT is active while `alert_pend` is 1 and the alert has not yet been served.
- R3: When the first byte after a START is `0x19` (address `0001100` with read bit 1) and the block participates, it pulls SDA low during the ninth SCL clock (ACK).
- R4: After the ACK it sends `0,0,1,1,strap[2],strap[1],strap[0],0`, MSB first. A 0 bit is sent by pulling SDA; a 1 bit is sent by releasing it.
- R5: After all eight bits have gone out without arbitration loss, EVENT goes inactive. It stays inactive and further alert queries are not acknowledged until `alert_pend` drops. A new alert then makes EVENT active again.
- R6: If the block releases SDA for a 1 bit but samples SDA low on the SCL rising edge, it stops driving for the rest of the transfer and EVENT stays active. The host then reads the lower competing address.
- R7: No ACK is given when `ara_en` is 0, `alert_pend` is 0, `int_mode` is 0, or `evt_pol` is 1.
- R8: Any other first byte, including the write form `0x18`, is not acknowledged and SDA is never driven in that transfer.
- R9: `sda_pull` changes only while SCL is low.
- R10: A START at any point restarts address reception, and a STOP returns the block to idle. A repeated START in the middle of the response ends it, and a following query is answered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_in | input | 1 | Synchronized SDA line level |
| scl_in | input | 1 | Synchronized SCL line level |
| strap_addr | input | 3 | Address strap pins, placed in bits 3..1 of the reply |
| int_mode | input | 1 | 1 = EVENT in interrupt mode |
| evt_pol | input | 1 | EVENT active level (0 = active-low) |
| ara_en | input | 1 | 1 = alert response enabled |
| alert_pend | input | 1 | 1 = an alert condition is pending |
| sda_pull | output | 1 | 1 = pull SDA low |
| evt_pin | output | 1 | EVENT pin level |

## Verification
The hardest case to reach is losing arbitration in the middle of the byte. A second target must pull the line low in exactly the bit where this block releases it. The bench models that rival inside its host task: it drives the rival's pull-down from the rival's own address bit during each low phase, and it drops out if the rival itself loses. Strap settings are chosen so that the block wins once and loses once. A repeated START that lands in a released bit of the reply checks the abort path.

// File: rtl/ara_responder.sv
module ara_responder #(
  parameter logic [6:0] ARA_ADDR  = 7'b0001100,
  parameter logic [3:0] ID_PREFIX = 4'b0011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic [2:0] strap_addr,
  input  logic       int_mode,
  input  logic       evt_pol,
  input  logic       ara_en,
  input  logic       alert_pend,
  output logic       sda_pull,
  output logic       evt_pin
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_SEND, S_DONE} st_t;

  st_t        st;
  logic       scl_q, sda_q, served, won;
  logic [3:0] cnt;
  logic [7:0] sh;

  wire       scl_rise  = ~scl_q & scl_in;
  wire       scl_fall  = scl_q & ~scl_in;
  wire       start_det = scl_q & scl_in & sda_q & ~sda_in;
  wire       stop_det  = scl_q & scl_in & ~sda_q & sda_in;
  wire       part      = ara_en & int_mode & ~evt_pol & alert_pend & ~served;
  wire [7:0] tx_byte   = {ID_PREFIX, strap_addr, 1'b0};

  assign evt_pin = (alert_pend && !served) ? evt_pol : ~evt_pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      served   <= 1'b0;
      won      <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      sda_pull <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (!alert_pend) served <= 1'b0;
      if (start_det) begin
        st       <= S_ADDR;
        cnt      <= '0;
        won      <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= S_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_in};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sh == {ARA_ADDR, 1'b1} && part) begin
                st       <= S_ACK;
                sda_pull <= 1'b1;
              end else begin
                st <= S_DONE;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              st       <= S_SEND;
              sh       <= tx_byte;
              cnt      <= '0;
              sda_pull <= ~tx_byte[7];
            end
          end
          S_SEND: begin
            if (scl_rise) begin
              if (!sda_pull && !sda_in) begin
                st <= S_DONE;
              end else if (cnt == 4'd7) begin
                won <= 1'b1;
                if (alert_pend) served <= 1'b1;
              end else begin
                cnt <= cnt + 4'd1;
              end
            end else if (scl_fall) begin
              if (won) begin
                sda_pull <= 1'b0;
                st       <= S_DONE;
              end else begin
                sh       <= {sh[6:0], 1'b0};
                sda_pull <= ~sh[6];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ara_responder_chk.sv
module ara_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       int_mode,
  input logic       evt_pol,
  input logic       alert_pend,
  input logic       sda_pull,
  input logic       evt_pin,
  input logic [2:0] st,
  input logic       start_det,
  input logic       stop_det
);
  a_r9_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !$past(scl_in));

  a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == 3'd1) && !sda_pull);

  a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (st == 3'd0) && !sda_pull);

  a_r7_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(int_mode && !evt_pol));

  a_r5_release_on_win: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_pend && $past(alert_pend) && $stable(evt_pol) && evt_pin != $past(evt_pin))
      |-> ($past(st) == 3'd3));
endmodule

bind ara_responder ara_responder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .int_mode(int_mode),
  .evt_pol(evt_pol), .alert_pend(alert_pend), .sda_pull(sda_pull),
  .evt_pin(evt_pin), .st(st), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/ara_responder_tb_top.sv
module ara_responder_tb_top;
  logic clk = 0, rst_n = 0;
  logic scl = 1, host_sda = 1, rival_pull = 0;
  logic [2:0] strap = 3'b101;
  logic int_mode = 1, evt_pol = 0, ara_en = 1, alert_pend = 1;
  logic sda_pull, evt_pin;
  wire  sda_line = host_sda & ~rival_pull & ~sda_pull;

  always #10 clk = ~clk;

  ara_responder dut_i (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_line), .scl_in(scl),
    .strap_addr(strap), .int_mode(int_mode), .evt_pol(evt_pol),
    .ara_en(ara_en), .alert_pend(alert_pend), .sda_pull(sda_pull), .evt_pin(evt_pin)
  );

  typedef struct { string tag; logic ack; logic [7:0] data; logic evt; } item_t;
  item_t exp_q[$], obs_q[$];
  int n_chk = 0, n_fail = 0, viol = 0;
  bit done = 0;
  logic pp = 0;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && sda_pull != pp && scl) viol++;
    pp = sda_pull;
  end

  task automatic bus_start();
    tick(1); scl = 0; tick(2); host_sda = 1; rival_pull = 0; tick(2);
    scl = 1; tick(2); host_sda = 0; tick(2); scl = 0;
  endtask

  task automatic bus_stop();
    tick(2); host_sda = 0; rival_pull = 0; tick(2); scl = 1; tick(2); host_sda = 1; tick(4);
  endtask

  task automatic clk_bit(input logic hb, input logic rv, output logic got);
    tick(2); host_sda = hb; rival_pull = rv; tick(2);
    scl = 1; tick(2); got = sda_line; tick(2); scl = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic g;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, g);
  endtask

  task automatic ara_txn(input logic [7:0] addr, input bit rival, input logic [7:0] rb,
                         output logic ack, output logic [7:0] data);
    logic g;
    bit ract;
    bus_start();
    send_byte(addr);
    clk_bit(1'b1, rival, g);
    ack = !g;
    ract = rival;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, ract & ~rb[i], g);
      data[i] = g;
      if (ract && rb[i] && !g) ract = 0;
    end
    clk_bit(1'b1, 1'b0, g);
    bus_stop();
  endtask

  task automatic run_case(input string tag, input logic [7:0] addr, input bit rival,
                          input logic [7:0] rb, input logic eack, input logic [7:0] edata,
                          input logic eevt);
    item_t e, o;
    logic a;
    logic [7:0] d;
    e.tag = tag; e.ack = eack; e.data = edata; e.evt = eevt;
    exp_q.push_back(e);
    ara_txn(addr, rival, rb, a, d);
    tick(3);
    o.tag = tag; o.ack = a; o.data = d; o.evt = evt_pin;
    obs_q.push_back(o);
    tick(1);
  endtask

  task automatic rearm();
    alert_pend = 0; tick(3); alert_pend = 1; tick(3);
  endtask

  initial begin
    item_t e, o;
    forever begin
      wait (obs_q.size() > 0);
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      check(o.ack == e.ack, {e.tag, " ack"}, {7'd0, o.ack}, {7'd0, e.ack});
      check(o.data == e.data, {e.tag, " byte"}, o.data, e.data);
      check(o.evt == e.evt, {e.tag, " event"}, {7'd0, o.evt}, {7'd0, e.evt});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic g, a;
    logic [7:0] d;
    tick(5); rst_n = 1; tick(2);
    check(sda_pull == 0, "R1 pull after reset", {7'd0, sda_pull}, 8'd0);
    check(evt_pin == 0, "R1 R2 event active low", {7'd0, evt_pin}, 8'd0);

    run_case("R3 R4 R5 lone win", 8'h19, 0, 8'hFF, 1, 8'h3A, 1);
    run_case("R5 served no ack", 8'h19, 0, 8'hFF, 0, 8'hFF, 1);
    alert_pend = 0; tick(2);
    check(evt_pin == 1, "R5 stays released", {7'd0, evt_pin}, 8'd1);
    alert_pend = 1; tick(2);
    check(evt_pin == 0, "R5 new alert", {7'd0, evt_pin}, 8'd0);

    strap = 3'b000;
    run_case("R6 win vs rival", 8'h19, 1, 8'h32, 1, 8'h30, 1);
    rearm(); strap = 3'b111;
    run_case("R6 lose vs rival", 8'h19, 1, 8'h30, 1, 8'h30, 0);

    strap = 3'b101; ara_en = 0;
    run_case("R7 disabled", 8'h19, 0, 8'hFF, 0, 8'hFF, 0);
    ara_en = 1; int_mode = 0;
    run_case("R7 comparator mode", 8'h19, 0, 8'hFF, 0, 8'hFF, 0);
    int_mode = 1; evt_pol = 1;
    run_case("R7 R2 high polarity", 8'h19, 0, 8'hFF, 0, 8'hFF, 1);
    evt_pol = 0; alert_pend = 0;
    run_case("R7 no alert", 8'h19, 0, 8'hFF, 0, 8'hFF, 1);
    alert_pend = 1; tick(2);
    run_case("R8 write form", 8'h18, 0, 8'hFF, 0, 8'hFF, 0);
    run_case("R8 other address", 8'h33, 0, 8'hFF, 0, 8'hFF, 0);

    bus_start();
    send_byte(8'h19);
    clk_bit(1'b1, 1'b0, g);
    check(g == 0, "R10 ack before restart", {7'd0, g}, 8'd0);
    for (int i = 0; i < 3; i++) clk_bit(1'b1, 1'b0, g);
    bus_start();
    tick(1);
    check(sda_pull == 0, "R10 released on restart", {7'd0, sda_pull}, 8'd0);
    send_byte(8'h19);
    clk_bit(1'b1, 1'b0, g);
    a = !g;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, 1'b0, g); d[i] = g; end
    clk_bit(1'b1, 1'b0, g);
    bus_stop(); tick(3);
    check(a == 1, "R10 ack after restart", {7'd0, a}, 8'd1);
    check(d == 8'h3A, "R10 R4 byte after restart", d, 8'h3A);
    check(evt_pin == 1, "R10 event released", {7'd0, evt_pin}, 8'd1);

    tick(5);
    check(viol == 0, "R9 pull changed with SCL high", viol[7:0], 8'd0);
    wait (obs_q.size() == 0);
    tick(2);
    finish_run();
  end
endmodule